// File: doc/BRIEF.md
# Packed unsigned maximum unit

This block takes two 256-bit operands and returns, for each lane, the larger value of the two, with both values compared as unsigned integers. One datapath serves both lane widths. An element-size input selects 8-bit lanes or 16-bit lanes. In word mode a 16-bit lane is always compared as a whole and is never split into two byte comparisons.

A two-bit form input sets what happens to the upper half of the destination:

- **Legacy 128-bit form:** the lower 128 bits carry the lane results. The upper 128 bits are copied unmodified from the old destination value supplied on a separate port. In this form the first operand stands for the destination.
- **Cleared 128-bit form:** the upper 128 bits are forced to zero.
- **Full 256-bit form:** every lane across the whole width is computed.
- **Reserved encoding:** the output is all zeros.

An optional output register, selected by a parameter, adds one cycle of latency. It carries a valid flag alongside the result and is cleared by a synchronous active-high reset.

Top module: `pumax_unit`

## Requirements
- R1: In byte mode (elem_word=0), every 8-bit lane of the computed range equals the unsigned maximum of the matching bytes of src_a and src_b. When the two bytes are equal, the lane takes that common value.
- R2: In word mode (elem_word=1), every 16-bit lane equals the unsigned maximum of the full 16-bit values. For example, src_a lane 0x01FF against src_b lane 0x0200 gives 0x0200, not 0x02FF.
- R3: With form=2'b00 (legacy 128), bits 127:0 hold the lane maxima and bits 255:128 equal old_dst[255:128]. The upper bits of src_a and src_b have no effect.
- R4: With form=2'b01 (cleared 128), bits 127:0 hold the lane maxima and bits 255:128 are zero, whatever the upper bits of src_a, src_b and old_dst are.
- R5: With form=2'b10 (full 256), all lanes across bits 255:0 hold the lane maxima: 32 byte lanes or 16 word lanes. old_dst has no effect.
- R6: With form=2'b11 (reserved), the result is all zeros.
- R7: With the output register enabled, the result and out_valid appear one clock after in_valid is sampled high. out_valid is low in the cycle after in_valid is sampled low.
- R8: While rst is sampled high, the registered result is cleared to zero and out_valid is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| src_a | input | 256 | First operand (destination in the legacy form) |
| src_b | input | 256 | Second operand |
| old_dst | input | 256 | Previous destination value, source of the kept upper half |
| elem_word | input | 1 | 0 = 8-bit lanes, 1 = 16-bit lanes |
| form | input | 2 | 00 legacy 128, 01 cleared 128, 10 full 256, 11 reserved |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Lane-wise unsigned maximum, shaped by form |

## Verification
The hardest case to reach from the ports is a word lane whose low byte would win a byte comparison while its high byte loses. Only that pattern reveals a word lane that has been split into two byte compares. The word sweep therefore injects carry-boundary pairs such as 0x01FF against 0x0200 into fixed lanes of every vector, and the remaining lanes carry pseudo-random pairs.

The byte sweep covers all 65,536 byte pairs, 32 lanes per vector, in the full form. Further vectors in the two 128-bit forms load the upper bits of the sources and old_dst with patterns that would surface in the result if they leaked through.

// File: rtl/pumax_pkg.sv
package pumax_pkg;

    localparam int unsigned VEC_W   = 256;
    localparam int unsigned HALF_W  = VEC_W / 2;
    localparam int unsigned CHUNK_W = 16;
    localparam int unsigned NCHUNK  = VEC_W / CHUNK_W;

    typedef enum logic [1:0] {
        FORM_KEEP128 = 2'b00,
        FORM_CLR128  = 2'b01,
        FORM_FULL256 = 2'b10,
        FORM_RSVD    = 2'b11
    } form_e;

    typedef enum logic {
        ESZ_BYTE = 1'b0,
        ESZ_WORD = 1'b1
    } esize_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] data;
    } vec_beat_t;

    function automatic logic [7:0] umax8(input logic [7:0] x, input logic [7:0] y);
        return (x > y) ? x : y;
    endfunction

    function automatic logic [15:0] umax16(input logic [15:0] x, input logic [15:0] y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/pumax_chunk.sv
module pumax_chunk
    import pumax_pkg::*;
(
    input  logic [CHUNK_W-1:0] a,
    input  logic [CHUNK_W-1:0] b,
    input  esize_e             esz,
    output logic [CHUNK_W-1:0] y
);
    localparam int unsigned BW = CHUNK_W / 2;

    logic [CHUNK_W-1:0] byte_pair;
    logic [CHUNK_W-1:0] whole;

    always_comb begin
        byte_pair[BW-1:0]       = umax8(a[BW-1:0], b[BW-1:0]);
        byte_pair[CHUNK_W-1:BW] = umax8(a[CHUNK_W-1:BW], b[CHUNK_W-1:BW]);
        whole                   = umax16(a, b);
        y = (esz == ESZ_WORD) ? whole : byte_pair;
    end

endmodule

// File: rtl/pumax_form_sel.sv
module pumax_form_sel
    import pumax_pkg::*;
(
    input  logic [VEC_W-1:0] lane_max,
    input  logic [VEC_W-1:0] old_dst,
    input  form_e            form,
    output logic [VEC_W-1:0] y
);
    always_comb begin
        unique case (form)
            FORM_KEEP128: y = {old_dst[VEC_W-1:HALF_W], lane_max[HALF_W-1:0]};
            FORM_CLR128:  y = {{HALF_W{1'b0}}, lane_max[HALF_W-1:0]};
            FORM_FULL256: y = lane_max;
            default:      y = '0;
        endcase
    end

endmodule

// File: rtl/pumax_out_reg.sv
module pumax_out_reg
    import pumax_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  vec_beat_t d,
    output vec_beat_t q
);
    generate
        if (REGISTERED) begin : g_reg
            vec_beat_t q_r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_r <= '0;
                end else begin
                    q_r.valid <= d.valid;
                    if (d.valid) q_r.data <= d.data;
                end
            end
            assign q = q_r;

            // R7
            p_latency_r7: assert property (@(posedge clk) disable iff (rst)
                d.valid |=> (q.valid && q.data == $past(d.data)));
            p_idle_r7: assert property (@(posedge clk) disable iff (rst)
                !d.valid |=> !q.valid);
            // R8
            p_reset_clear_r8: assert property (@(posedge clk)
                rst |=> (q.valid == 1'b0 && q.data == '0));
        end else begin : g_comb
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/pumax_unit.sv
module pumax_unit
    import pumax_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    input  logic [VEC_W-1:0]   old_dst,
    input  logic               elem_word,
    input  logic [1:0]         form,
    output logic               out_valid,
    output logic [VEC_W-1:0]   result
);
    esize_e           esz;
    form_e            form_sel;
    logic [VEC_W-1:0] lane_max;
    logic [VEC_W-1:0] shaped;
    vec_beat_t        beat_d;
    vec_beat_t        beat_q;

    assign esz      = esize_e'(elem_word);
    assign form_sel = form_e'(form);

    generate
        for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
            pumax_chunk u_chunk (
                .a   (src_a[c*CHUNK_W +: CHUNK_W]),
                .b   (src_b[c*CHUNK_W +: CHUNK_W]),
                .esz (esz),
                .y   (lane_max[c*CHUNK_W +: CHUNK_W])
            );
        end
    endgenerate

    pumax_form_sel u_form (
        .lane_max (lane_max),
        .old_dst  (old_dst),
        .form     (form_sel),
        .y        (shaped)
    );

    assign beat_d.valid = in_valid;
    assign beat_d.data  = shaped;

    pumax_out_reg #(.REGISTERED(REG_OUT)) u_oreg (
        .clk (clk),
        .rst (rst),
        .d   (beat_d),
        .q   (beat_q)
    );

    assign out_valid = beat_q.valid;
    assign result    = beat_q.data;

    generate
        if (REG_OUT) begin : g_chk
            // R3
            p_keep_upper_r3: assert property (@(posedge clk) disable iff (rst)
                (in_valid && form == 2'b00) |=> result[VEC_W-1:HALF_W] == $past(old_dst[VEC_W-1:HALF_W]));
            // R4
            p_clear_upper_r4: assert property (@(posedge clk) disable iff (rst)
                (in_valid && form == 2'b01) |=> result[VEC_W-1:HALF_W] == '0);
            // R5
            p_equal_ops_r5: assert property (@(posedge clk) disable iff (rst)
                (in_valid && form == 2'b10 && src_a == src_b) |=> result == $past(src_a));
            // R6
            p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
                (in_valid && form == 2'b11) |=> result == '0);
        end
    endgenerate

endmodule

// File: tb/pumax_unit_bench.sv
`timescale 1ns/1ps
module pumax_unit_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [255:0] src_a, src_b, old_dst;
    logic         elem_word;
    logic [1:0]   form;
    logic         out_valid;
    logic [255:0] result;

    int unsigned total = 0;
    int unsigned bad   = 0;
    logic [31:0] seed  = 32'h1357_9bdf;

    always #2.5 clk = ~clk;

    pumax_unit u_pumax_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
        .elem_word(elem_word), .form(form),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t = s;
        t = t ^ (t << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic logic [255:0] model(input logic [255:0] a, input logic [255:0] b,
                                           input logic [255:0] o, input logic w,
                                           input logic [1:0] m);
        logic [255:0] mx;
        if (w) begin
            for (int i = 0; i < 16; i++)
                mx[i*16 +: 16] = (a[i*16 +: 16] > b[i*16 +: 16]) ? a[i*16 +: 16] : b[i*16 +: 16];
        end else begin
            for (int i = 0; i < 32; i++)
                mx[i*8 +: 8] = (a[i*8 +: 8] > b[i*8 +: 8]) ? a[i*8 +: 8] : b[i*8 +: 8];
        end
        case (m)
            2'b00:   return {o[255:128], mx[127:0]};
            2'b01:   return {128'd0, mx[127:0]};
            2'b10:   return mx;
            default: return 256'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one beat at a falling edge; check it at the next falling edge
    task automatic beat(input string req, input logic [255:0] a, input logic [255:0] b,
                        input logic [255:0] o, input logic w, input logic [1:0] m);
        logic [255:0] e;
        e = model(a, b, o, w, m);
        src_a = a; src_b = b; old_dst = o; elem_word = w; form = m; in_valid = 1'b1;
        @(negedge clk);
        check(req, result, e);
        check({req, " valid R7"}, {255'd0, out_valid}, 256'd1);
    endtask

    function automatic logic [255:0] rnd_vec();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) begin
            seed = nxt(seed);
            v[i*32 +: 32] = seed;
        end
        return v;
    endfunction

    initial begin
        #500000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [255:0] a, b, o;
        rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; old_dst = '0;
        elem_word = 1'b0; form = 2'b10;
        repeat (3) @(negedge clk);
        check("R8 reset result", result, 256'd0);
        check("R8 reset valid", {255'd0, out_valid}, 256'd0);
        rst = 1'b0;

        // R1: exhaustive byte pairs, full form
        for (int k = 0; k < 2048; k++) begin
            for (int i = 0; i < 32; i++) begin
                logic [15:0] p;
                p = 16'(k * 32 + i);
                a[i*8 +: 8] = p[15:8];
                b[i*8 +: 8] = p[7:0];
            end
            beat("R1 byte full", a, b, rnd_vec(), 1'b0, 2'b10);
        end

        // R2 / R5: word lanes with carry-boundary pairs in fixed lanes
        for (int k = 0; k < 600; k++) begin
            a = rnd_vec(); b = rnd_vec();
            a[15:0]    = 16'h01FF; b[15:0]    = 16'h0200;
            a[31:16]   = 16'h0300; b[31:16]   = 16'h02FF;
            a[47:32]   = 16'hFFFF; b[47:32]   = 16'h0000;
            a[63:48]   = 16'h8000; b[63:48]   = 16'h7FFF;
            a[143:128] = 16'h00FF; b[143:128] = 16'h0100;
            b[95:80]   = a[95:80];
            beat("R2 R5 word full", a, b, rnd_vec(), 1'b1, 2'b10);
        end

        // R3: legacy form, both sizes, upper source bits loaded
        for (int k = 0; k < 300; k++) begin
            a = rnd_vec(); b = rnd_vec(); o = rnd_vec();
            b[255:128] = '1;
            beat("R3 keep upper", a, b, o, k[0], 2'b00);
        end

        // R4: cleared form
        for (int k = 0; k < 300; k++) begin
            a = rnd_vec(); b = rnd_vec(); o = '1;
            a[255:128] = '1;
            beat("R4 clear upper", a, b, o, k[0], 2'b01);
        end

        // R5: equal operands in full form
        a = rnd_vec();
        beat("R5 equal full byte", a, a, '1, 1'b0, 2'b10);
        beat("R5 equal full word", a, a, '1, 1'b1, 2'b10);

        // R6: reserved form
        for (int k = 0; k < 20; k++)
            beat("R6 reserved", rnd_vec(), rnd_vec(), rnd_vec(), k[0], 2'b11);

        // R7: idle beat drops out_valid and holds the result
        a = result;
        in_valid = 1'b0; src_a = rnd_vec();
        @(negedge clk);
        check("R7 idle valid", {255'd0, out_valid}, 256'd0);
        check("R7 idle hold", result, a);
        beat("R7 resume", 256'd5, 256'd9, 256'd0, 1'b0, 2'b10);

        // R8: reset during valid traffic
        rst = 1'b1; in_valid = 1'b1; src_a = '1;
        @(negedge clk);
        check("R8 midrun result", result, 256'd0);
        check("R8 midrun valid", {255'd0, out_valid}, 256'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule